// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block performs unsigned 16-bit multiplication and division on an accumulator pair made of a low word A and a high word Y. A caller presents the operation select, the source operand and the present A and Y values, then strobes `start`. The unit works through an iterative loop and finally raises `done` for one cycle. In that cycle it shows the new A and Y values, a write enable for each, the carry and overflow updates, and error and break flag set pulses. The caller writes these into its own register file and flag register.

Multiplication forms the 32-bit product of A and the source with a shift-add loop of 16 steps. Y is written only when the upper half of the product is nonzero, and carry and overflow report that case. Division joins Y (upper) and A (lower) into a 32-bit dividend and divides it by the source with a restoring shift-subtract loop of 32 steps. The floored quotient, cut to 16 bits, goes to A and the remainder goes to Y. A zero divisor leaves A and Y untouched and raises the error and break flags at once.

Top module: `muldiv_unit`

## Requirements
- R1: With `op_sel` = 0 (multiply), the unit sets `a_out` to the low 16 bits of `a_in` × `src` and asserts `a_we`. It also asserts `carry_we` and `ovf_we`, and it never asserts `err_set` or `brk_set`.
- R2: For a multiply whose product upper half is nonzero, the unit sets `y_out` to that upper half and asserts `y_we`, with `carry_out` = `ovf_out` = 1. When the upper half is zero, `y_we` stays low and `carry_out` = `ovf_out` = 0.
- R3: With `op_sel` = 1 (divide) and a nonzero `src`, the unit divides the unsigned dividend {`y_in`,`a_in`}. It sets `a_out` to the low 16 bits of the floored quotient and `y_out` to the remainder, and asserts both `a_we` and `y_we`. It leaves `carry_we`, `ovf_we`, `err_set` and `brk_set` low.
- R4: A divide whose quotient needs more than 16 bits keeps only the low 16 bits of the quotient in `a_out`. The remainder in `y_out` is still exact.
- R5: A divide with `src` = 0 pulses `err_set` and `brk_set` together with `done`. `a_we`, `y_we`, `carry_we` and `ovf_we` all stay low in that case.
- R6: Rising edges are counted after the edge that samples `start`. For a multiply, `done` is high in the cycle that follows the 17th such edge. For a nonzero divide, it is high after the 33rd. For a zero-divisor divide, it is high in the cycle right after the sampling edge.
- R7: `busy` is high from the sampling edge until `done` rises, and it is never high in the same cycle as `done`. A `start` that arrives while `busy` is high is ignored: the running operation keeps its result and its timing.
- R8: `a_we`, `y_we`, `carry_we`, `ovf_we`, `err_set` and `brk_set` are asserted only in a cycle where `done` is high. After reset, `done`, `busy` and all of these outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when not busy) |
| op_sel | input | 1 | 0 = multiply, 1 = divide |
| src | input | 16 | Source operand (multiplier or divisor) |
| a_in | input | 16 | Present A (low accumulator word) |
| y_in | input | 16 | Present Y (high accumulator word) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| a_out | output | 16 | New A value |
| a_we | output | 1 | Write A with `a_out` |
| y_out | output | 16 | New Y value |
| y_we | output | 1 | Write Y with `y_out` |
| carry_we | output | 1 | Update carry flag |
| carry_out | output | 1 | New carry flag value |
| ovf_we | output | 1 | Update overflow flag |
| ovf_out | output | 1 | New overflow flag value |
| err_set | output | 1 | Set error flag |
| brk_set | output | 1 | Set break flag |

## Verification
The assertions check on every cycle that each write enable and flag pulse occurs only together with `done` and never overlaps `busy`. They also check that error and break rise as a pair with no accumulator write, that a flag-updating multiply reports carry and overflow equal to its Y write, and that a busy stretch never outlasts the divide loop. Only the bench scenarios can show the arithmetic itself: products and quotients against a reference model, quotient truncation, the exact latency of each operation kind, and that a stray `start` during a run leaves its result unchanged.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    MD_MUL = 1'b0,
    MD_DIV = 1'b1
  } md_op_e;
endpackage

// File: rtl/md_mul_engine.sv
// Shift-add multiplier: one partial product per step, LSB first.
module md_mul_engine #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0] hi_q, lo_q, mcand_q;
  logic [W:0]   psum;
  logic [2*W:0] shifted;

  always_comb begin
    psum    = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    shifted = {psum, lo_q} >> 1;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      hi_q    <= '0;
      lo_q    <= mplier_i;
      mcand_q <= mcand_i;
    end else if (step) begin
      hi_q <= shifted[2*W-1:W];
      lo_q <= shifted[W-1:0];
    end
  end

  assign prod_o = {hi_q, lo_q};
endmodule

// File: rtl/md_div_engine.sv
// Restoring divider: one quotient bit per step, MSB first.
module md_div_engine #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic [2*W-1:0] quo_o,
  output logic [W-1:0]   rem_o
);
  logic [W:0]     rem_q;
  logic [2*W-1:0] quo_q;
  logic [W-1:0]   dsr_q;
  logic [W:0]     rem_shl;
  logic [W+1:0]   trial;

  always_comb begin
    rem_shl = {rem_q[W-1:0], quo_q[2*W-1]};
    trial   = {1'b0, rem_shl} - {2'b00, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rem_q <= '0;
      quo_q <= dividend_i;
      dsr_q <= divisor_i;
    end else if (step) begin
      if (!trial[W+1]) begin
        rem_q <= trial[W:0];
        quo_q <= {quo_q[2*W-2:0], 1'b1};
      end else begin
        rem_q <= rem_shl;
        quo_q <= {quo_q[2*W-2:0], 1'b0};
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q[W-1:0];
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_sel,
  input  logic [W-1:0] src,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] y_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] a_out,
  output logic         a_we,
  output logic [W-1:0] y_out,
  output logic         y_we,
  output logic         carry_we,
  output logic         carry_out,
  output logic         ovf_we,
  output logic         ovf_out,
  output logic         err_set,
  output logic         brk_set
);
  import muldiv_pkg::*;

  localparam int DIV_STEPS = 2 * W;
  localparam int CNT_W     = $clog2(DIV_STEPS);
  localparam logic [CNT_W-1:0] MUL_LAST = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_STEPS - 1);

  md_op_e         op_q;
  logic           running, fin;
  logic [CNT_W-1:0] cnt;
  logic           accept, div_zero;
  logic [2*W-1:0] prod;
  logic [2*W-1:0] quo;
  logic [W-1:0]   rem;
  logic           prod_hi_nz;

  assign accept   = start && !busy;
  assign div_zero = (md_op_e'(op_sel) == MD_DIV) && (src == '0);
  assign busy     = running || fin;
  assign prod_hi_nz = |prod[2*W-1:W];

  md_mul_engine #(.W(W)) u_mul (
    .clk      (clk),
    .load     (accept),
    .step     (running && op_q == MD_MUL),
    .mcand_i  (src),
    .mplier_i (a_in),
    .prod_o   (prod)
  );

  md_div_engine #(.W(W)) u_div (
    .clk        (clk),
    .load       (accept),
    .step       (running && op_q == MD_DIV),
    .dividend_i ({y_in, a_in}),
    .divisor_i  (src),
    .quo_o      (quo),
    .rem_o      (rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= MD_MUL;
      running   <= 1'b0;
      fin       <= 1'b0;
      cnt       <= '0;
      done      <= 1'b0;
      a_out     <= '0;
      y_out     <= '0;
      a_we      <= 1'b0;
      y_we      <= 1'b0;
      carry_we  <= 1'b0;
      carry_out <= 1'b0;
      ovf_we    <= 1'b0;
      ovf_out   <= 1'b0;
      err_set   <= 1'b0;
      brk_set   <= 1'b0;
    end else begin
      done      <= 1'b0;
      a_we      <= 1'b0;
      y_we      <= 1'b0;
      carry_we  <= 1'b0;
      carry_out <= 1'b0;
      ovf_we    <= 1'b0;
      ovf_out   <= 1'b0;
      err_set   <= 1'b0;
      brk_set   <= 1'b0;
      if (accept) begin
        op_q <= md_op_e'(op_sel);
        cnt  <= '0;
        if (div_zero) begin
          done    <= 1'b1;
          err_set <= 1'b1;
          brk_set <= 1'b1;
          a_out   <= a_in;
          y_out   <= y_in;
        end else begin
          running <= 1'b1;
        end
      end else if (running) begin
        cnt <= cnt + 1'b1;
        if (cnt == ((op_q == MD_MUL) ? MUL_LAST : DIV_LAST)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end else if (fin) begin
        fin  <= 1'b0;
        done <= 1'b1;
        a_we <= 1'b1;
        if (op_q == MD_MUL) begin
          a_out     <= prod[W-1:0];
          y_out     <= prod[2*W-1:W];
          y_we      <= prod_hi_nz;
          carry_we  <= 1'b1;
          ovf_we    <= 1'b1;
          carry_out <= prod_hi_nz;
          ovf_out   <= prod_hi_nz;
        end else begin
          a_out <= quo[W-1:0];
          y_out <= rem;
          y_we  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 16
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic a_we,
  input logic y_we,
  input logic carry_we,
  input logic carry_out,
  input logic ovf_we,
  input logic ovf_out,
  input logic err_set,
  input logic brk_set
);
  localparam int LEN_W = $clog2(4 * W);
  logic [LEN_W-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else busy_len <= '0;
  end

  a_r8_pulses_with_done: assert property (@(posedge clk) disable iff (rst)
    (a_we || y_we || carry_we || ovf_we || err_set || brk_set) |-> done);

  a_r7_no_done_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  a_r5_err_brk_no_write: assert property (@(posedge clk) disable iff (rst)
    (err_set || brk_set) |-> (err_set && brk_set && !a_we && !y_we && !carry_we && !ovf_we));

  a_r2_flags_track_y_write: assert property (@(posedge clk) disable iff (rst)
    carry_we |-> (ovf_we && carry_out == y_we && ovf_out == y_we));

  a_r1_mul_writes_a: assert property (@(posedge clk) disable iff (rst)
    carry_we |-> (a_we && !err_set));

  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_len < LEN_W'(2 * W + 1)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .a_we      (a_we),
  .y_we      (y_we),
  .carry_we  (carry_we),
  .carry_out (carry_out),
  .ovf_we    (ovf_we),
  .ovf_out   (ovf_out),
  .err_set   (err_set),
  .brk_set   (brk_set)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, op_sel = 1'b0;
  logic [W-1:0] src = '0, a_in = '0, y_in = '0;
  logic busy, done, a_we, y_we, carry_we, carry_out, ovf_we, ovf_out, err_set, brk_set;
  logic [W-1:0] a_out, y_out;

  int n_vec = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .src(src),
    .a_in(a_in), .y_in(y_in), .busy(busy), .done(done),
    .a_out(a_out), .a_we(a_we), .y_out(y_out), .y_we(y_we),
    .carry_we(carry_we), .carry_out(carry_out), .ovf_we(ovf_we),
    .ovf_out(ovf_out), .err_set(err_set), .brk_set(brk_set)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model: returns packed {a, a_we, y, y_we, cwe, c, owe, o, err, brk}
  typedef struct packed {
    logic [W-1:0] a; logic awe; logic [W-1:0] y; logic ywe;
    logic cwe; logic c; logic owe; logic o; logic err; logic brk;
  } exp_t;

  function automatic exp_t model(input logic op, input logic [W-1:0] s,
                                 input logic [W-1:0] a, input logic [W-1:0] y);
    exp_t e;
    logic [2*W-1:0] p, dd, q, r;
    e = '0;
    if (!op) begin
      p = {{W{1'b0}}, a} * {{W{1'b0}}, s};
      e.a = p[W-1:0]; e.awe = 1'b1;
      e.ywe = (p[2*W-1:W] != 0);
      e.y = p[2*W-1:W];
      e.cwe = 1'b1; e.owe = 1'b1; e.c = e.ywe; e.o = e.ywe;
    end else if (s == 0) begin
      e.a = a; e.y = y; e.err = 1'b1; e.brk = 1'b1;
    end else begin
      dd = {y, a};
      q = dd / {{W{1'b0}}, s};
      r = dd % {{W{1'b0}}, s};
      e.a = q[W-1:0]; e.y = r[W-1:0]; e.awe = 1'b1; e.ywe = 1'b1;
    end
    return e;
  endfunction

  // Runs one operation; optionally pulses a stray start at cycle 'stray_at'.
  task automatic run_op(input logic op, input logic [W-1:0] s, input logic [W-1:0] a,
                        input logic [W-1:0] y, input int stray_at, input string tag);
    exp_t e;
    int cycles, exp_cyc;
    e = model(op, s, a, y);
    exp_cyc = (!op) ? W + 2 : ((s == 0) ? 1 : 2 * W + 2);
    @(negedge clk);
    op_sel = op; src = s; a_in = a; y_in = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 200) begin
      if (cycles == stray_at) begin
        op_sel = ~op; src = s ^ 16'h5a5a; a_in = ~a; y_in = y + 16'd7; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    check({tag, " R6"}, "latency", cycles, exp_cyc);
    check({tag, " R1/R3"}, "a_we", a_we, e.awe);
    if (e.awe) check({tag, " R1 R3 R4"}, "a_out", a_out, e.a);
    check({tag, " R2 R3"}, "y_we", y_we, e.ywe);
    if (e.ywe) check({tag, " R2 R3"}, "y_out", y_out, e.y);
    check({tag, " R1 R3"}, "carry_we", carry_we, e.cwe);
    check({tag, " R2"}, "carry_out", carry_out, e.c);
    check({tag, " R1 R3"}, "ovf_we", ovf_we, e.owe);
    check({tag, " R2"}, "ovf_out", ovf_out, e.o);
    check({tag, " R5"}, "err_set", err_set, e.err);
    check({tag, " R5"}, "brk_set", brk_set, e.brk);
    check({tag, " R7"}, "busy_at_done", busy, 1'b0);
    // pulses drop in the following cycle if no new start
    @(negedge clk);
    check({tag, " R8"}, "done_drops", done, 1'b0);
    check({tag, " R8"}, "we_drop", {a_we, y_we, carry_we, ovf_we, err_set, brk_set}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h1a2b3c4d);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8", "reset done", done, 1'b0);
    check("R8", "reset busy", busy, 1'b0);
    check("R8", "reset enables", {a_we, y_we, carry_we, ovf_we, err_set, brk_set}, 0);

    // Directed corners
    run_op(1'b0, 16'd5, 16'd3, 16'h1234, -1, "mul small (R2 no Y)");
    run_op(1'b0, 16'hffff, 16'hffff, 16'h0, -1, "mul max (R2 Y)");
    run_op(1'b0, 16'h0, 16'hbeef, 16'h1, -1, "mul zero");
    run_op(1'b0, 16'h0100, 16'h0100, 16'h0, -1, "mul hi=1");
    run_op(1'b1, 16'd7, 16'd100, 16'd0, -1, "div basic");
    run_op(1'b1, 16'd1, 16'h0000, 16'h0001, -1, "div trunc R4");
    run_op(1'b1, 16'd3, 16'hffff, 16'hffff, -1, "div trunc R4 big");
    run_op(1'b1, 16'hffff, 16'hfffe, 16'hfffe, -1, "div max divisor");
    run_op(1'b1, 16'd0, 16'h1111, 16'h2222, -1, "div zero R5");
    run_op(1'b0, 16'd9, 16'd11, 16'd0, 5, "mul stray start R7");
    run_op(1'b1, 16'd13, 16'h4321, 16'd12, 20, "div stray start R7");
    run_op(1'b1, 16'd0, 16'h0, 16'h0, -1, "div zero R5 zeros");

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      logic op;
      logic [W-1:0] s, a, y;
      op = $urandom_range(0, 1) == 1;
      a  = W'($urandom);
      y  = W'($urandom);
      case ($urandom_range(0, 5))
        0: s = '0;
        1: s = W'($urandom_range(1, 15));
        default: s = W'($urandom);
      endcase
      if (op && s != 0 && $urandom_range(0, 1) == 1) y = W'(y % s);
      run_op(op, s, a, y, ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 16)) : -1,
             op ? "rand div R3" : "rand mul R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule